// File: doc/BRIEF.md
# Coprocessor Context Transfer Sequencer

This block sits on the main-processor side of a register-mapped coprocessor link. It runs the two control exchanges that come before a context move. A restore writes a caller-supplied format word into the coprocessor's restore register, reads the word back to learn whether the coprocessor accepted it, and then polls the response register until the coprocessor reports completion. A save reads the coprocessor's save register to learn the format of the context the coprocessor holds. Moving the context data itself and building stack frames are left to other logic.

A format error is never reported as a response primitive. The coprocessor signals it only by returning the reserved invalid-format code in the low byte of the save or restore register. When the sequencer sees that code, it writes the abort mask to the control register. It then raises a one-cycle exception request that carries format-error vector 14 and the four-word pre-instruction frame type (code 0). Because the frame type is pre-instruction, the interrupted operation restarts when the handler returns. A response word whose primitive is not defined is a protocol violation. The sequencer pulses a flag, sends the same abort, and requests vector 13.

Every register access is a single request held on a 16-bit bus until the coprocessor raises ready. The registers sit at byte offsets 0x0 (response), 0x2 (control), 0x4 (save) and 0x6 (restore).

Top module: `cpctx_seq`

## Requirements
- R1: After reset, bus_req, done, exc_req, proto_viol, exc_vector, frame_type and save_fmt are all zero.
- R2: A restore starts with a write of restore_word to offset 0x6, followed by a read of offset 0x6.
- R3: If the low byte of the restore read-back is 0x1F, the sequencer writes 0x0002 to offset 0x2. When that write completes, it pulses exc_req with exc_vector 14 and frame_type 0, and gives no done.
- R4: If the read-back is valid, the sequencer reads offset 0x0. A response whose high byte is 0x08 ends the restore with a one-cycle done pulse and no exc_req.
- R5: A response whose high byte is 0x09 (busy) causes offset 0x0 to be read again, once per busy response.
- R6: A response whose high byte is neither 0x08 nor 0x09 pulses proto_viol in the same cycle the abort write (0x0002 to offset 0x2) is put on the bus. When that write completes, exc_req pulses with exc_vector 13 and frame_type 0.
- R7: A save makes exactly one read of offset 0x4. If the low byte is not 0x1F, done pulses and save_fmt takes that low byte.
- R8: If the save read returns 0x1F in its low byte, the sequencer takes the R3 abort and vector-14 exception path, and save_fmt keeps its previous value.
- R9: While bus_req is high and bus_ready is low, bus_req, bus_we, bus_addr and bus_wdata hold steady. Each access completes exactly once, in the cycle where both are high.
- R10: Start commands that arrive while an operation is in progress are ignored. When start_restore and start_save arrive together from idle, the restore runs.
- R11: Every operation ends with exactly one done or one exc_req, never both. After that the bus is idle and the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_save | input | 1 | Begin a context save (single-cycle pulse) |
| start_restore | input | 1 | Begin a context restore (single-cycle pulse) |
| restore_word | input | 16 | Format word written to the restore register |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 4 | Byte offset of the interface register |
| bus_wdata | output | 16 | Write data |
| bus_ready | input | 1 | Coprocessor completes the current access |
| bus_rdata | input | 16 | Read data, valid when bus_ready is high |
| done | output | 1 | Operation finished normally (single-cycle pulse) |
| save_fmt | output | 8 | Format code from the last successful save |
| exc_req | output | 1 | Exception request (single-cycle pulse) |
| exc_vector | output | 8 | Vector number of the last exception request |
| frame_type | output | 4 | Stack-frame type of the last exception request |
| proto_viol | output | 1 | Undefined response primitive seen (single-cycle pulse) |

## Verification
Assertions check, on every cycle, the properties that do not depend on history. A stalled request stays frozen. Every write goes either to the restore register or carries the abort mask to the control register. A protocol-violation pulse coincides with the abort write. An exception always carries vector 13 or 14 with frame type 0. Done and exception never coincide, and neither appears while an access is outstanding. Only the bench scenarios can show the full ordering of bus accesses, and the sweeps make that ordering visible. They cover every restore format byte, every response primitive byte and every save format byte, under several stall patterns. The scenarios also show how busy responses are counted, that save_fmt is retained after an invalid save, and that start commands issued mid-operation are ignored.

// File: rtl/cpctx_pkg.sv
package cpctx_pkg;

  // byte offsets of the coprocessor interface registers
  localparam int OFF_RESP    = 0;
  localparam int OFF_CTRL    = 2;
  localparam int OFF_SAVE    = 4;
  localparam int OFF_RESTORE = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_WR,
    ST_RST_RD,
    ST_RSP_RD,
    ST_SAV_RD,
    ST_ABORT
  } seq_state_t;

endpackage

// File: rtl/cpctx_bus.sv
// Single-outstanding register access master. A new access may be launched
// in the same cycle the previous one completes.
module cpctx_bus #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  output logic          ack
);

  assign ack = bus_req & bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (go) begin
      bus_req   <= 1'b1;
      bus_we    <= go_we;
      bus_addr  <= go_addr;
      bus_wdata <= go_wdata;
    end else if (ack) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
    end
  end

endmodule

// File: rtl/cpctx_decode.sv
// Classifies a register word as a format code (low field) and as a
// response primitive (high field).
module cpctx_decode #(
  parameter int          DW          = 16,
  parameter int          FW          = 8,
  parameter logic [FW-1:0] FMT_INVALID = 8'h1F,
  parameter logic [FW-1:0] PRIM_DONE   = 8'h08,
  parameter logic [FW-1:0] PRIM_BUSY   = 8'h09
) (
  input  logic [DW-1:0] word,
  output logic          fmt_bad,
  output logic          prim_done,
  output logic          prim_busy,
  output logic          prim_bad
);

  logic [FW-1:0] prim;

  assign prim      = word[DW-1 -: FW];
  assign fmt_bad   = (word[FW-1:0] == FMT_INVALID);
  assign prim_done = (prim == PRIM_DONE);
  assign prim_busy = (prim == PRIM_BUSY);
  assign prim_bad  = !prim_done && !prim_busy;

endmodule

// File: rtl/cpctx_seq.sv
module cpctx_seq #(
  parameter int              DW          = 16,
  parameter int              AW          = 4,
  parameter int              FW          = 8,
  parameter int              VW          = 8,
  parameter int              TW          = 4,
  parameter logic [FW-1:0]   FMT_INVALID = 8'h1F,
  parameter logic [FW-1:0]   PRIM_DONE   = 8'h08,
  parameter logic [FW-1:0]   PRIM_BUSY   = 8'h09,
  parameter logic [DW-1:0]   ABORT_MASK  = 16'h0002,
  parameter logic [VW-1:0]   FMT_VEC     = 8'd14,
  parameter logic [VW-1:0]   PROTO_VEC   = 8'd13,
  parameter logic [TW-1:0]   FRAME_PRE4  = 4'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_save,
  input  logic          start_restore,
  input  logic [DW-1:0] restore_word,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic [FW-1:0] save_fmt,
  output logic          exc_req,
  output logic [VW-1:0] exc_vector,
  output logic [TW-1:0] frame_type,
  output logic          proto_viol
);

  import cpctx_pkg::*;

  localparam logic [AW-1:0] A_RESP    = AW'(OFF_RESP);
  localparam logic [AW-1:0] A_CTRL    = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_SAVE    = AW'(OFF_SAVE);
  localparam logic [AW-1:0] A_RESTORE = AW'(OFF_RESTORE);

  seq_state_t    state, nxt;
  logic          go, go_we;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_wdata;
  logic          ack;
  logic          fmt_bad, prim_done, prim_busy, prim_bad;
  logic          fin_ok, fin_save, raise_proto, raise_exc;
  logic          pend_proto;

  cpctx_bus #(.DW(DW), .AW(AW)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .ack       (ack)
  );

  cpctx_decode #(
    .DW(DW), .FW(FW), .FMT_INVALID(FMT_INVALID),
    .PRIM_DONE(PRIM_DONE), .PRIM_BUSY(PRIM_BUSY)
  ) u_dec (
    .word      (bus_rdata),
    .fmt_bad   (fmt_bad),
    .prim_done (prim_done),
    .prim_busy (prim_busy),
    .prim_bad  (prim_bad)
  );

  always_comb begin
    nxt         = state;
    go          = 1'b0;
    go_we       = 1'b0;
    go_addr     = A_RESP;
    go_wdata    = '0;
    fin_ok      = 1'b0;
    fin_save    = 1'b0;
    raise_proto = 1'b0;
    raise_exc   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_restore) begin
          go       = 1'b1;
          go_we    = 1'b1;
          go_addr  = A_RESTORE;
          go_wdata = restore_word;
          nxt      = ST_RST_WR;
        end else if (start_save) begin
          go      = 1'b1;
          go_addr = A_SAVE;
          nxt     = ST_SAV_RD;
        end
      end
      ST_RST_WR: begin
        if (ack) begin
          go      = 1'b1;
          go_addr = A_RESTORE;
          nxt     = ST_RST_RD;
        end
      end
      ST_RST_RD: begin
        if (ack) begin
          go = 1'b1;
          if (fmt_bad) begin
            go_we    = 1'b1;
            go_addr  = A_CTRL;
            go_wdata = ABORT_MASK;
            nxt      = ST_ABORT;
          end else begin
            go_addr = A_RESP;
            nxt     = ST_RSP_RD;
          end
        end
      end
      ST_RSP_RD: begin
        if (ack) begin
          if (prim_done) begin
            fin_ok = 1'b1;
            nxt    = ST_IDLE;
          end else if (prim_busy) begin
            go      = 1'b1;
            go_addr = A_RESP;
          end else if (prim_bad) begin
            raise_proto = 1'b1;
            go          = 1'b1;
            go_we       = 1'b1;
            go_addr     = A_CTRL;
            go_wdata    = ABORT_MASK;
            nxt         = ST_ABORT;
          end
        end
      end
      ST_SAV_RD: begin
        if (ack) begin
          if (fmt_bad) begin
            go       = 1'b1;
            go_we    = 1'b1;
            go_addr  = A_CTRL;
            go_wdata = ABORT_MASK;
            nxt      = ST_ABORT;
          end else begin
            fin_save = 1'b1;
            nxt      = ST_IDLE;
          end
        end
      end
      ST_ABORT: begin
        if (ack) begin
          raise_exc = 1'b1;
          nxt       = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pend_proto <= 1'b0;
      done       <= 1'b0;
      exc_req    <= 1'b0;
      proto_viol <= 1'b0;
      exc_vector <= '0;
      frame_type <= '0;
      save_fmt   <= '0;
    end else begin
      state      <= nxt;
      done       <= fin_ok | fin_save;
      exc_req    <= raise_exc;
      proto_viol <= raise_proto;
      if (go && nxt == ST_ABORT)
        pend_proto <= raise_proto;
      if (raise_exc) begin
        exc_vector <= pend_proto ? PROTO_VEC : FMT_VEC;
        frame_type <= FRAME_PRE4;
      end
      if (fin_save)
        save_fmt <= bus_rdata[FW-1:0];
    end
  end

endmodule

// File: rtl/cpctx_seq_chk.sv
module cpctx_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int VW = 8,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          done,
  input logic          exc_req,
  input logic [VW-1:0] exc_vector,
  input logic [TW-1:0] frame_type,
  input logic          proto_viol
);

  import cpctx_pkg::*;

  localparam logic [AW-1:0] A_CTRL    = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_RESTORE = AW'(OFF_RESTORE);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) &&
                                 $stable(bus_addr) && $stable(bus_wdata)));

  // R2
  write_target_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> (bus_addr == A_RESTORE ||
                             (bus_addr == A_CTRL && bus_wdata == 16'h0002)));

  // R6
  proto_abort_chk: assert property (@(posedge clk) disable iff (rst)
    proto_viol |-> (bus_req && bus_we && bus_addr == A_CTRL &&
                    bus_wdata == 16'h0002));

  // R3
  exc_fields_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (frame_type == 4'h0 &&
                 (exc_vector == 8'd14 || exc_vector == 8'd13)));

  // R11
  single_end_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && exc_req));

  // R11
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || exc_req) |-> !bus_req);

endmodule

bind cpctx_seq cpctx_seq_chk #(.DW(DW), .AW(AW), .VW(VW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready),
  .done       (done),
  .exc_req    (exc_req),
  .exc_vector (exc_vector),
  .frame_type (frame_type),
  .proto_viol (proto_viol)
);

// File: tb/tb_cpctx_seq.sv
`timescale 1ns/1ps
module tb_cpctx_seq;
  localparam int DW = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, start_save, start_restore;
  logic [DW-1:0] restore_word;
  logic          bus_req, bus_we, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          done, exc_req, proto_viol;
  logic [7:0]    save_fmt, exc_vector;
  logic [3:0]    frame_type;

  cpctx_seq dut (
    .clk(clk), .rst(rst), .start_save(start_save), .start_restore(start_restore),
    .restore_word(restore_word), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .done(done), .save_fmt(save_fmt), .exc_req(exc_req),
    .exc_vector(exc_vector), .frame_type(frame_type), .proto_viol(proto_viol)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // coprocessor model
  logic [15:0] m_restore = 16'h0, m_save = 16'h0, m_prim = 16'h0800;
  int m_busy = 0, stall = 0, cyc = 0;

  function automatic bit fmt_valid(input logic [7:0] b);
    return (b == 8'h00 || b == 8'h21 || b == 8'h41 || b == 8'h60);
  endfunction

  assign bus_ready = bus_req && (stall == 0 || (cyc % (stall + 1)) == stall);

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = (m_busy > 0) ? 16'h0900 : m_prim;
      4'h4:    bus_rdata = m_save;
      4'h6:    bus_rdata = m_restore;
      default: bus_rdata = 16'h0;
    endcase
  end

  // transaction log and pulse counters
  logic [AW-1:0] l_addr [16];
  logic          l_we   [16];
  logic [15:0]   l_wd   [16];
  int l_n = 0, n_done = 0, n_exc = 0, n_proto = 0;
  logic [7:0] last_vec = 0;
  logic [3:0] last_frame = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && bus_ready) begin
      if (l_n < 16) begin
        l_addr[l_n] = bus_addr; l_we[l_n] = bus_we; l_wd[l_n] = bus_wdata;
      end
      l_n = l_n + 1;
      if (bus_we && bus_addr == 4'h6)
        m_restore <= fmt_valid(bus_wdata[7:0]) ? bus_wdata : 16'h001F;
      if (!bus_we && bus_addr == 4'h0 && m_busy > 0)
        m_busy <= m_busy - 1;
    end
    if (done) n_done = n_done + 1;
    if (exc_req) begin
      n_exc = n_exc + 1; last_vec = exc_vector; last_frame = frame_type;
    end
    if (proto_viol) n_proto = n_proto + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ent(input string req, input int i, input logic [3:0] a,
                         input logic w, input logic [15:0] d);
    chk(req, {11'd0, l_we[i], l_addr[i], l_wd[i]}, {11'd0, w, a, (w ? d : l_wd[i])});
  endtask

  task automatic clear_obs();
    l_n = 0; n_done = 0; n_exc = 0; n_proto = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (n_done + n_exc > 0) break;
    end
    repeat (2) @(negedge clk);
    chk("R11 one end", 32'(n_done + n_exc), 32'd1);
    chk("R11 bus idle", {31'd0, bus_req}, 32'd0);
  endtask

  // mode: 0 plain, 1 poke starts mid-run, 2 both starts together
  task automatic run_restore(input logic [15:0] w, input logic [15:0] prim,
                             input int nb, input int st, input int mode);
    bit ok = fmt_valid(w[7:0]);
    int e;
    @(negedge clk);
    m_prim = prim; m_busy = nb; stall = st; clear_obs();
    restore_word = w; start_restore = 1'b1;
    if (mode == 2) start_save = 1'b1;
    @(negedge clk);
    start_restore = 1'b0; start_save = 1'b0;
    if (mode == 1) begin
      @(negedge clk); start_save = 1'b1; start_restore = 1'b1;
      @(negedge clk); start_save = 1'b0; start_restore = 1'b0;
    end
    wait_end();
    chk_ent("R2 write restore", 0, 4'h6, 1'b1, w);
    chk_ent("R2 read restore", 1, 4'h6, 1'b0, 16'h0);
    if (!ok) begin
      chk("R3 count", 32'(l_n), 32'd3);
      chk_ent("R3 abort write", 2, 4'h2, 1'b1, 16'h0002);
      chk("R3 exc", 32'(n_exc), 32'd1);
      chk("R3 vec", {24'd0, last_vec}, 32'd14);
      chk("R3 frame", {28'd0, last_frame}, 32'd0);
      chk("R3 no done", 32'(n_done), 32'd0);
    end else begin
      for (int i = 0; i <= nb; i++) chk_ent("R5 resp read", 2 + i, 4'h0, 1'b0, 16'h0);
      e = 3 + nb;
      if (prim[15:8] == 8'h08) begin
        chk(mode != 0 ? "R10 count" : "R4 count", 32'(l_n), 32'(e));
        chk("R4 done", 32'(n_done), 32'd1);
        chk("R4 no exc", 32'(n_exc), 32'd0);
      end else begin
        chk("R6 count", 32'(l_n), 32'(e + 1));
        chk_ent("R6 abort write", e, 4'h2, 1'b1, 16'h0002);
        chk("R6 proto", 32'(n_proto), 32'd1);
        chk("R6 vec", {24'd0, last_vec}, 32'd13);
        chk("R6 frame", {28'd0, last_frame}, 32'd0);
      end
    end
  endtask

  task automatic run_save(input logic [7:0] b, input int st, input logic [7:0] prev_fmt);
    @(negedge clk);
    m_save = {8'h3C, b}; stall = st; clear_obs();
    start_save = 1'b1;
    @(negedge clk);
    start_save = 1'b0;
    wait_end();
    chk_ent("R7 read save", 0, 4'h4, 1'b0, 16'h0);
    if (b == 8'h1F) begin
      chk("R8 count", 32'(l_n), 32'd2);
      chk_ent("R8 abort write", 1, 4'h2, 1'b1, 16'h0002);
      chk("R8 vec", {24'd0, last_vec}, 32'd14);
      chk("R8 fmt kept", {24'd0, save_fmt}, {24'd0, prev_fmt});
    end else begin
      chk("R7 count", 32'(l_n), 32'd1);
      chk("R7 done", 32'(n_done), 32'd1);
      chk("R7 fmt", {24'd0, save_fmt}, {24'd0, b});
    end
  endtask

  initial begin
    logic [7:0] sf;
    rst = 1'b1; start_save = 1'b0; start_restore = 1'b0; restore_word = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req", {31'd0, bus_req}, 32'd0);
    chk("R1 pulses", {29'd0, done, exc_req, proto_viol}, 32'd0);
    chk("R1 fields", {12'd0, exc_vector, frame_type, save_fmt}, 32'd0);
    // R2 R3 R4 R5 R9: every restore format byte, varied busy count and stalls
    for (int i = 0; i < 256; i++)
      run_restore({8'hA5, 8'(i)}, 16'h0800, i % 3, i % 3, 0);
    // R6: every response primitive byte except busy
    for (int i = 0; i < 256; i++)
      if (i != 9) run_restore(16'h0021, {8'(i), 8'h5A}, i % 2, 1, 0);
    // R7 R8: every save format byte
    sf = 8'h00;
    for (int i = 0; i < 256; i++) begin
      run_save(8'(i), i % 4, sf);
      if (i != 8'h1F) sf = 8'(i);
    end
    // R10: starts while busy ignored, restore wins when both arrive
    run_restore(16'h0041, 16'h0800, 2, 3, 1);
    run_restore(16'h0060, 16'h0800, 0, 0, 2);
    // R11: back-to-back error then normal operation accepted
    run_restore(16'h0077, 16'h0800, 0, 0, 0);
    run_save(8'h21, 0, 8'hFF);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule